// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations for 8 KB pages. Each of its entries pairs a virtual page number with a physical page number, and each entry is also tagged with an address-space number. Translations that belong to different processes can therefore stay resident side by side, and a context switch does not require the buffer to be emptied. Every entry also holds two permission bits, and these are checked whenever the entry matches a lookup.

The lookup port takes a virtual address, the current address-space number and the kind of access being made. In the same cycle it reports exactly one of three outcomes: a hit with the physical address, a protection fault, or a miss. When the lookup misses, the surrounding logic walks the page table and then writes the result back through the refill port. The block chooses the slot for each refill itself. A flush input removes translations, either all of them or only those of one address space.

Top module: `asn_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry matches both the virtual page number (`lk_va[31:13]`) and `lk_asn`, and the access is permitted, `lk_hit` is high in the same cycle. In that case `lk_pa` equals the entry's physical page number concatenated above `lk_va[12:0]`.
- R2: In every cycle with `lk_valid` high, exactly one of `lk_hit`, `lk_fault` and `lk_miss` is high. When no valid entry matches, `lk_miss` is high. `lk_pa` is zero whenever the outcome is not a hit. All three outcome outputs are low when `lk_valid` is low.
- R3: Two entries with the same virtual page number but different address-space numbers can coexist. A lookup that uses an address-space number with no matching entry misses.
- R4: The permission bit `perm[0]` set to 1 means writable; set to 0 it means read-only. The bit `perm[1]` set to 1 means user-accessible; set to 0 it means kernel-only. A matching lookup faults when `lk_write` is high and the entry is read-only, or when `lk_user` is high and the entry is kernel-only.
- R5: A refill accepted at a clock edge can be looked up from the next cycle onward.
- R6: A refill for a new translation goes to the lowest-numbered invalid entry. As long as any entry is invalid, no valid entry is displaced, so 128 distinct refills into an empty buffer all remain resident.
- R7: When all entries are valid, a new translation replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping at the last entry, only when it has been used for a replacement.
- R8: A refill whose virtual page number and address-space number are already present overwrites that entry. It does not create a duplicate and does not move the round-robin pointer.
- R9: When `fl_all` is high at a clock edge, every entry becomes invalid.
- R10: When `fl_asn_en` is high at a clock edge, only the entries whose address-space number equals `fl_asn` become invalid.
- R11: A refill presented in the same cycle as either flush is dropped.
- R12: After reset, every entry is invalid and the round-robin pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_asn | input | 8 | Address-space number of the current process |
| lk_write | input | 1 | The access is a write |
| lk_user | input | 1 | The access is made in user mode |
| lk_hit | output | 1 | The lookup matched and is permitted |
| lk_fault | output | 1 | The lookup matched but breaks the permissions |
| lk_miss | output | 1 | No valid entry matched |
| lk_pa | output | 32 | Physical address on a hit; zero otherwise |
| rf_en | input | 1 | Write a translation this cycle |
| rf_vpn | input | 19 | Virtual page number to install |
| rf_asn | input | 8 | Address-space number to install |
| rf_ppn | input | 19 | Physical page number to install |
| rf_perm | input | 2 | Permission bits to install (bit 0 writable, bit 1 user) |
| fl_all | input | 1 | Invalidate every entry |
| fl_asn_en | input | 1 | Invalidate the entries of one address space |
| fl_asn | input | 8 | Address space selected for that flush |

## Verification
The bench looks up the same virtual page under two address spaces to separate a true match from a match on the page number alone. It then tries reads and writes in kernel and user mode against entries carrying each permission combination, to separate a hit from a fault. Filling all 128 entries and then adding new pages shows that free slots are used before any valid entry is evicted, and that evictions proceed in round-robin order. A repeated refill of a page that is already present must change the translation in place and leave that order unchanged. Flushes by address space, full flushes, and a refill that coincides with a flush show which entries survive each kind of invalidation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        LK_NONE,
        LK_HIT,
        LK_FAULT,
        LK_MISS
    } lk_result_e;

    localparam int PERM_W   = 2;
    localparam int PERM_WR  = 0;   // 1 = writable, 0 = read-only
    localparam int PERM_USR = 1;   // 1 = user may access, 0 = kernel only
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
    parameter int VPN_W  = 19,
    parameter int PPN_W  = 19,
    parameter int ASN_W  = 8,
    parameter int PERM_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASN_W-1:0]  wr_asn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              flush_all,
    input  logic              flush_asn_en,
    input  logic [ASN_W-1:0]  flush_asn,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [ASN_W-1:0]  cmp_asn,
    output logic              lk_match,
    output logic              rf_match,
    output logic              valid_o,
    output logic [PERM_W-1:0] perm_o,
    output logic [PPN_W-1:0]  ppn_o
);
    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASN_W-1:0]  asn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PERM_W-1:0] perm_q;

    // Flushes win over a write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (flush_all || (flush_asn_en && (asn_q == flush_asn))) begin
            valid_q <= 1'b0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q  <= wr_vpn;
            asn_q  <= wr_asn;
            ppn_q  <= wr_ppn;
            perm_q <= wr_perm;
        end
    end

    assign lk_match = valid_q && (vpn_q == cmp_vpn) && (asn_q == cmp_asn);
    assign rf_match = valid_q && (vpn_q == wr_vpn)  && (asn_q == wr_asn);
    assign valid_o  = valid_q;
    assign perm_o   = perm_q;
    assign ppn_o    = ppn_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rf_fire,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] rf_match_vec,
    output logic [IDX_W-1:0]   slot_sel
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             have_match;
    logic             have_free;
    logic             use_rr;

    // Scan downward so the lowest index is the one kept.
    always_comb begin
        have_match = 1'b0;
        have_free  = 1'b0;
        match_idx  = '0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (rf_match_vec[i]) begin
                have_match = 1'b1;
                match_idx  = IDX_W'(i);
            end
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign use_rr   = !have_match && !have_free;
    assign slot_sel = have_match ? match_idx : (have_free ? free_idx : rr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (rf_fire && use_rr) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 13,
    parameter int ASN_W   = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASN_W-1:0]  lk_asn,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASN_W-1:0]  rf_asn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              fl_all,
    input  logic              fl_asn_en,
    input  logic [ASN_W-1:0]  fl_asn
);
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] wr_vec;
    logic [PPN_W-1:0]   ppn_arr  [ENTRIES];
    logic [PERM_W-1:0]  perm_arr [ENTRIES];
    logic [IDX_W-1:0]   slot_sel;
    logic               rf_fire;
    logic [PPN_W-1:0]   sel_ppn;
    logic [PERM_W-1:0]  sel_perm;
    lk_result_e         res;

    assign rf_fire = rf_en && !fl_all && !fl_asn_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign wr_vec[g] = rf_fire && (slot_sel == IDX_W'(g));
        tlb_entry #(
            .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .PERM_W(PERM_W)
        ) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_vec[g]),
            .wr_vpn       (rf_vpn),
            .wr_asn       (rf_asn),
            .wr_ppn       (rf_ppn),
            .wr_perm      (rf_perm),
            .flush_all    (fl_all),
            .flush_asn_en (fl_asn_en),
            .flush_asn    (fl_asn),
            .cmp_vpn      (lk_va[VA_W-1:OFF_W]),
            .cmp_asn      (lk_asn),
            .lk_match     (lk_match[g]),
            .rf_match     (rf_match[g]),
            .valid_o      (valid_vec[g]),
            .perm_o       (perm_arr[g]),
            .ppn_o        (ppn_arr[g])
        );
    end

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk          (clk),
        .rst_n        (rst_n),
        .rf_fire      (rf_fire),
        .valid_vec    (valid_vec),
        .rf_match_vec (rf_match),
        .slot_sel     (slot_sel)
    );

    // At most one entry matches, so an OR across the entries selects it.
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_ppn  = sel_ppn  | ppn_arr[i];
                sel_perm = sel_perm | perm_arr[i];
            end
        end
    end

    always_comb begin
        if (!lk_valid) begin
            res = LK_NONE;
        end else if (lk_match == '0) begin
            res = LK_MISS;
        end else if ((lk_write && !sel_perm[PERM_WR]) ||
                     (lk_user  && !sel_perm[PERM_USR])) begin
            res = LK_FAULT;
        end else begin
            res = LK_HIT;
        end
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_fault = 1'b0;
        lk_miss  = 1'b0;
        lk_pa    = '0;
        unique case (res)
            LK_NONE:  ;
            LK_HIT: begin
                lk_hit = 1'b1;
                lk_pa  = {sel_ppn, lk_va[OFF_W-1:0]};
            end
            LK_FAULT: lk_fault = 1'b1;
            LK_MISS:  lk_miss  = 1'b1;
        endcase
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int ENTRIES = 128,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 13,
    parameter int ASN_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lk_valid,
    input logic [VA_W-1:0]       lk_va,
    input logic [ASN_W-1:0]      lk_asn,
    input logic                  lk_hit,
    input logic                  lk_fault,
    input logic                  lk_miss,
    input logic [PA_W-1:0]       lk_pa,
    input logic                  rf_en,
    input logic [VA_W-OFF_W-1:0] rf_vpn,
    input logic [ASN_W-1:0]      rf_asn,
    input logic                  fl_all,
    input logic                  fl_asn_en,
    input logic [ENTRIES-1:0]    lk_match
);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_fault, lk_miss}) == 1));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault && !lk_miss));

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

    assert_fault_no_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_pa == '0));

    assert_refill_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rf_en) && !$past(fl_all) && !$past(fl_asn_en) && lk_valid &&
         (lk_va[VA_W-1:OFF_W] == $past(rf_vpn)) && (lk_asn == $past(rf_asn)))
        |-> !lk_miss);

    assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_all) && lk_valid) |-> lk_miss);

    assert_no_duplicate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind asn_tlb tlb_checker #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ASN_W(ASN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_va     (lk_va),
    .lk_asn    (lk_asn),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .lk_miss   (lk_miss),
    .lk_pa     (lk_pa),
    .rf_en     (rf_en),
    .rf_vpn    (rf_vpn),
    .rf_asn    (rf_asn),
    .fl_all    (fl_all),
    .fl_asn_en (fl_asn_en),
    .lk_match  (lk_match)
);

// File: tb/tb_asn_tlb.sv
module tb_asn_tlb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asn = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_fault, lk_miss;
    logic [31:0] lk_pa;
    logic        rf_en = 1'b0;
    logic [18:0] rf_vpn = '0;
    logic [7:0]  rf_asn = '0;
    logic [18:0] rf_ppn = '0;
    logic [1:0]  rf_perm = '0;
    logic        fl_all = 1'b0;
    logic        fl_asn_en = 1'b0;
    logic [7:0]  fl_asn = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // flags = {hit, fault, miss}
    typedef struct {
        logic [2:0]  flags;
        logic [31:0] pa;
        string       req;
    } exp_t;
    exp_t sb[$];

    localparam logic [2:0] E_HIT   = 3'b100;
    localparam logic [2:0] E_FAULT = 3'b010;
    localparam logic [2:0] E_MISS  = 3'b001;

    asn_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asn(lk_asn),
        .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss), .lk_pa(lk_pa),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_asn(rf_asn), .rf_ppn(rf_ppn),
        .rf_perm(rf_perm), .fl_all(fl_all), .fl_asn_en(fl_asn_en), .fl_asn(fl_asn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: compares one scoreboard item per cycle, away from the edge.
    exp_t e;
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if ({lk_hit, lk_fault, lk_miss} !== e.flags || lk_pa !== e.pa) begin
                fails++;
                $display("FAIL %s: got flags=%b pa=%h, expected flags=%b pa=%h",
                         e.req, {lk_hit, lk_fault, lk_miss}, lk_pa, e.flags, e.pa);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        lk_valid = 0; lk_write = 0; lk_user = 0;
        rf_en = 0; fl_all = 0; fl_asn_en = 0;
    endtask

    task automatic refill(input logic [18:0] vpn, input logic [7:0] asn,
                          input logic [18:0] ppn, input logic [1:0] perm);
        cyc();
        rf_en = 1; rf_vpn = vpn; rf_asn = asn; rf_ppn = ppn; rf_perm = perm;
    endtask

    task automatic lookup(input logic [18:0] vpn, input logic [12:0] off,
                          input logic [7:0] asn, input logic wr, input logic usr,
                          input logic [2:0] flags, input logic [18:0] ppn,
                          input string req);
        exp_t x;
        cyc();
        lk_valid = 1; lk_va = {vpn, off}; lk_asn = asn;
        lk_write = wr; lk_user = usr;
        x.flags = flags;
        x.pa    = (flags == E_HIT) ? {ppn, off} : 32'h0;
        x.req   = req;
        sb.push_back(x);
    endtask

    task automatic idle_check(input string req);
        exp_t x;
        cyc();
        x.flags = 3'b000; x.pa = 32'h0; x.req = req;
        sb.push_back(x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R12: empty after reset
        lookup(19'h10, 13'h0ABC, 8'd3, 0, 0, E_MISS, 0, "R12 reset empty");
        idle_check("R2 idle outputs low");

        // R1/R5: refill then hit next cycle
        refill(19'h10, 8'd3, 19'h00055, 2'b11);
        lookup(19'h10, 13'h0ABC, 8'd3, 0, 1, E_HIT, 19'h00055, "R1 R5 hit");
        // R3: other address space misses
        lookup(19'h10, 13'h0ABC, 8'd4, 0, 0, E_MISS, 0, "R3 asn mismatch");
        lookup(19'h11, 13'h0001, 8'd3, 0, 0, E_MISS, 0, "R2 vpn mismatch");
        // R3: same page, second address space, read-only kernel
        refill(19'h10, 8'd4, 19'h00066, 2'b00);
        lookup(19'h10, 13'h1FFF, 8'd4, 0, 0, E_HIT, 19'h00066, "R3 second asn");
        lookup(19'h10, 13'h0000, 8'd3, 1, 1, E_HIT, 19'h00055, "R3 first asn kept");
        // R4: permission faults
        lookup(19'h10, 13'h0123, 8'd4, 1, 0, E_FAULT, 0, "R4 write to read-only");
        lookup(19'h10, 13'h0123, 8'd4, 0, 1, E_FAULT, 0, "R4 user to kernel page");
        refill(19'h20, 8'd3, 19'h00077, 2'b01);
        lookup(19'h20, 13'h0042, 8'd3, 1, 0, E_HIT, 19'h00077, "R4 kernel write ok");
        lookup(19'h20, 13'h0042, 8'd3, 1, 1, E_FAULT, 0, "R4 user write kernel page");

        // R10: flush address space 3 only
        cyc(); fl_asn_en = 1; fl_asn = 8'd3;
        lookup(19'h10, 13'h0ABC, 8'd3, 0, 0, E_MISS, 0, "R10 flushed asn");
        lookup(19'h20, 13'h0ABC, 8'd3, 0, 0, E_MISS, 0, "R10 flushed asn 2");
        lookup(19'h10, 13'h0ABC, 8'd4, 0, 0, E_HIT, 19'h00066, "R10 other asn kept");

        // R11/R9: refill together with full flush is dropped
        refill(19'h30, 8'd5, 19'h00088, 2'b11);
        fl_all = 1;
        lookup(19'h10, 13'h0ABC, 8'd4, 0, 0, E_MISS, 0, "R9 flush all");
        lookup(19'h30, 13'h0ABC, 8'd5, 0, 0, E_MISS, 0, "R11 refill dropped");

        // R6: fill all 128 entries, all stay resident
        for (int i = 0; i < 128; i++)
            refill(19'(19'h100 + i), 8'd1, 19'(19'h2000 + i), 2'b11);
        for (int i = 0; i < 128; i++)
            lookup(19'(19'h100 + i), 13'(i * 7), 8'd1, 1, 1, E_HIT,
                   19'(19'h2000 + i), "R6 full buffer resident");

        // R7: round-robin from entry 0
        refill(19'h500, 8'd1, 19'h03000, 2'b11);
        lookup(19'h100, 13'h0, 8'd1, 0, 0, E_MISS, 0, "R7 entry 0 evicted");
        lookup(19'h101, 13'h0, 8'd1, 0, 0, E_HIT, 19'h02001, "R7 entry 1 kept");
        lookup(19'h500, 13'h0010, 8'd1, 0, 0, E_HIT, 19'h03000, "R7 new page");
        refill(19'h501, 8'd1, 19'h03001, 2'b11);
        lookup(19'h101, 13'h0, 8'd1, 0, 0, E_MISS, 0, "R7 entry 1 evicted");
        lookup(19'h102, 13'h0, 8'd1, 0, 0, E_HIT, 19'h02002, "R7 entry 2 kept");

        // R8: duplicate refill overwrites in place, pointer unchanged
        refill(19'h105, 8'd1, 19'h07777, 2'b11);
        lookup(19'h105, 13'h0444, 8'd1, 0, 0, E_HIT, 19'h07777, "R8 overwrite");
        refill(19'h502, 8'd1, 19'h03002, 2'b11);
        lookup(19'h102, 13'h0, 8'd1, 0, 0, E_MISS, 0, "R8 pointer not moved");
        lookup(19'h103, 13'h0, 8'd1, 0, 0, E_HIT, 19'h02003, "R8 next still kept");
        lookup(19'h105, 13'h0001, 8'd1, 0, 0, E_HIT, 19'h07777, "R8 single copy");

        // R6: a hole made by an address-space flush is reused first
        refill(19'h600, 8'd9, 19'h04000, 2'b11);   // evicts entry 3 (0x103)
        cyc(); fl_asn_en = 1; fl_asn = 8'd9;       // entry 3 now invalid
        refill(19'h601, 8'd1, 19'h04001, 2'b11);   // fills entry 3
        lookup(19'h104, 13'h0, 8'd1, 0, 0, E_HIT, 19'h02004, "R6 hole reused first");
        lookup(19'h601, 13'h0, 8'd1, 0, 0, E_HIT, 19'h04001, "R6 hole filled");

        cyc();
        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule